// File: doc/BRIEF.md
# Channel Access Scheduler for a Half-Duplex Packet Radio

This block sits between a packet transmit engine and a radio front end and decides the cycle in which a pending packet may key the transmitter. Two configuration bits choose one of four access policies: send at once; wait a fixed, slot-numbered delay computed from the packet's own airtime; listen and send as soon as the channel is quiet; or listen and, whenever the channel is busy, release the receiver for a random back-off before listening again.

All time is counted in units of 12.5 µs, produced by a prescaler from the system clock; a back-off millisecond is a parameterised number of those units. The block reports a receiver-enable request while it listens and a single-cycle grant pulse when transmission may start. It is built around one state machine with six states: `ST_IDLE` (nothing pending), `ST_SLOT` (fixed delay running), `ST_LISTEN` (receiver on, quiet time accumulating), `ST_BACKOFF` (receiver off, random delay running), `ST_GRANT` (grant pulse) and `ST_HOLD` (waiting for the request to be withdrawn). Transitions: idle to grant (both bits clear), idle to slot (delay only), idle to listen (listen bit set); slot to grant when its count is spent; listen to grant after a full quiet window, listen to back-off on busy with delay bit set, listen stays in listen on busy otherwise; back-off to listen when its count is spent; grant to hold always; hold to idle when the request drops; every waiting state (slot, listen, back-off) to idle when the request drops.

Top module: `lbt_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rx_enable` and `tx_grant` are low.
- R2: With `cfg_listen`=0 and `cfg_delay`=0, `tx_grant` goes high in the cycle after the clock edge that first samples `tx_pending` high, and `rx_enable` stays low.
- R3: The slot length in 12.5 µs units is `pre_cycles` + (`pkt_bytes` + 2) × 6 + 3 × `turn_units` + 40.
- R4: With `cfg_listen`=0 and `cfg_delay`=1, the grant appears `slot_num` × slot length × CLKS_PER_UNIT + 1 clock edges after the edge that samples the request, regardless of `chan_busy`, with `rx_enable` low throughout.
- R5: With `cfg_listen`=1, `rx_enable` is high while listening and the grant follows only after `chan_busy` has been low for `turn_units` full units: `turn_units` × CLKS_PER_UNIT + 1 edges after the last edge that sampled busy high (or after the request edge). `turn_units` is valid from 1 to 255.
- R6: With `cfg_listen`=1 and `cfg_delay`=0, a busy channel holds the block listening with `rx_enable` high and no grant, for as long as busy lasts.
- R7: With `cfg_listen`=1 and `cfg_delay`=1, a busy sample drops `rx_enable` for a back-off of R × UNITS_PER_MS × CLKS_PER_UNIT + 1 cycles, R between 0 and 2^`backoff_exp` − 1, then listening resumes; for `backoff_exp`=0 the gap is exactly one cycle.
- R8: R is drawn from a free-running 16-bit maximal-length LFSR masked to `backoff_exp` bits, so successive back-offs differ.
- R9: Dropping `tx_pending` during any wait returns the block to idle on the next edge: `rx_enable` low, and no grant for that request.
- R10: The grant lasts exactly one cycle, and one request yields one grant until `tx_pending` is withdrawn.
- R11: A grant is never raised together with `rx_enable`, and never without the request having been high on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_listen | input | 1 | Policy bit: check the channel before sending |
| cfg_delay | input | 1 | Policy bit: fixed slot delay (listen off) or random back-off (listen on) |
| tx_pending | input | 1 | A packet waits to be sent; held until granted, drop to abort |
| chan_busy | input | 1 | Receive detector reports activity on the channel |
| backoff_exp | input | 3 | Back-off exponent n; maximum back-off (2^n − 1) ms |
| slot_num | input | 8 | Slot index for the fixed-delay policy |
| pre_cycles | input | 8 | Preamble length in 12.5 µs cycles |
| turn_units | input | 8 | Turnaround delay in 12.5 µs units, 1 to 255 |
| pkt_bytes | input | 6 | Packet length in bytes |
| rx_enable | output | 1 | Receiver-enable request while listening |
| tx_grant | output | 1 | One-cycle pulse: transmission may start |

## Verification
The bench builds the block with CLKS_PER_UNIT=2 and UNITS_PER_MS=4, keeping the real slot-formula constants, so a unit is two clocks and a back-off millisecond eight clocks. That makes every slot delay of slot numbers 0 to 3 across two preamble lengths, the shortest and longest packet and two turnaround values reachable within a few thousand cycles each, so the fixed-delay policy is swept almost exhaustively with exact cycle counts. The short millisecond lets many back-offs be measured for exponents 0 to 3 against their arithmetic bound, and the quiet window is swept for turnaround values 1 to 6.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_LISTEN,
        ST_BACKOFF,
        ST_GRANT,
        ST_HOLD
    } sched_state_t;

endpackage

// File: rtl/lbt_tick.sv
module lbt_tick #(
    parameter int DIV = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (clr || pre_q == PW'(DIV - 1)) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick = (pre_q == PW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/lbt_lfsr.sv
module lbt_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] q;
    logic         fb;

    // x^16 + x^14 + x^13 + x^11 + 1, maximal length
    assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= W'(SEED);
        end else begin
            q <= {q[W-2:0], fb};
        end
    end

    assign value = q;
endmodule

// File: rtl/lbt_slot_len.sv
module lbt_slot_len #(
    parameter int PRE_W       = 8,
    parameter int TURN_W      = 8,
    parameter int LEN_W       = 6,
    parameter int SLOT_W      = 14,
    parameter int BYTE_UNITS  = 6,
    parameter int GUARD_UNITS = 40
) (
    input  logic [PRE_W-1:0]  pre_cycles,
    input  logic [TURN_W-1:0] turn_units,
    input  logic [LEN_W-1:0]  pkt_bytes,
    output logic [SLOT_W-1:0] slot_units
);
    logic [SLOT_W-1:0] pre_part;
    logic [SLOT_W-1:0] body_part;
    logic [SLOT_W-1:0] turn_part;

    always_comb begin
        pre_part   = SLOT_W'(pre_cycles);
        body_part  = (SLOT_W'(pkt_bytes) + SLOT_W'(2)) * SLOT_W'(BYTE_UNITS);
        turn_part  = SLOT_W'(turn_units) * SLOT_W'(3);
        slot_units = pre_part + body_part + turn_part + SLOT_W'(GUARD_UNITS);
    end
endmodule

// File: rtl/lbt_sched.sv
module lbt_sched
    import lbt_pkg::*;
#(
    parameter int CLKS_PER_UNIT = 1250,
    parameter int UNITS_PER_MS  = 80,
    parameter int BYTE_UNITS    = 6,
    parameter int GUARD_UNITS   = 40,
    parameter int EXP_W         = 3,
    parameter int SLOT_NUM_W    = 8,
    parameter int PRE_W         = 8,
    parameter int TURN_W        = 8,
    parameter int LEN_W         = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_listen,
    input  logic                  cfg_delay,
    input  logic                  tx_pending,
    input  logic                  chan_busy,
    input  logic [EXP_W-1:0]      backoff_exp,
    input  logic [SLOT_NUM_W-1:0] slot_num,
    input  logic [PRE_W-1:0]      pre_cycles,
    input  logic [TURN_W-1:0]     turn_units,
    input  logic [LEN_W-1:0]      pkt_bytes,
    output logic                  rx_enable,
    output logic                  tx_grant
);
    localparam int SLOT_W  = TURN_W + LEN_W;
    localparam int CNT_W   = SLOT_W + SLOT_NUM_W;
    localparam int RAND_W  = (1 << EXP_W) - 1;
    localparam int LFSR_W  = 16;

    sched_state_t state_q, state_d;

    logic [CNT_W-1:0]  wait_cnt;
    logic [TURN_W-1:0] quiet_cnt;
    logic              quiet_done;
    logic              tick;
    logic              tick_clr;
    logic [SLOT_W-1:0] slot_units;
    logic [CNT_W-1:0]  slot_delay;
    logic [LFSR_W-1:0] rand_word;
    logic [RAND_W-1:0] rand_mask;
    logic [RAND_W-1:0] rand_ms;
    logic [CNT_W-1:0]  backoff_load;

    lbt_tick #(.DIV(CLKS_PER_UNIT)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    lbt_lfsr #(.W(LFSR_W), .SEED(16'hACE1)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rand_word)
    );

    lbt_slot_len #(
        .PRE_W       (PRE_W),
        .TURN_W      (TURN_W),
        .LEN_W       (LEN_W),
        .SLOT_W      (SLOT_W),
        .BYTE_UNITS  (BYTE_UNITS),
        .GUARD_UNITS (GUARD_UNITS)
    ) u_slot (
        .pre_cycles (pre_cycles),
        .turn_units (turn_units),
        .pkt_bytes  (pkt_bytes),
        .slot_units (slot_units)
    );

    // Delay loads
    assign slot_delay   = CNT_W'(slot_num) * CNT_W'(slot_units);
    assign rand_mask    = RAND_W'((32'd1 << backoff_exp) - 32'd1);
    assign rand_ms      = rand_word[RAND_W-1:0] & rand_mask;
    assign backoff_load = CNT_W'(rand_ms) * CNT_W'(UNITS_PER_MS);
    assign quiet_done   = (quiet_cnt >= turn_units);

    // Restart the time base on every state change and while busy is heard
    assign tick_clr = (state_d != state_q) || (state_q == ST_LISTEN && chan_busy);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_pending) begin
                    if (cfg_listen) begin
                        state_d = ST_LISTEN;
                    end else if (cfg_delay) begin
                        state_d = ST_SLOT;
                    end else begin
                        state_d = ST_GRANT;
                    end
                end
            end
            ST_SLOT: begin
                if (!tx_pending) begin
                    state_d = ST_IDLE;
                end else if (wait_cnt == '0) begin
                    state_d = ST_GRANT;
                end
            end
            ST_LISTEN: begin
                if (!tx_pending) begin
                    state_d = ST_IDLE;
                end else if (chan_busy) begin
                    state_d = cfg_delay ? ST_BACKOFF : ST_LISTEN;
                end else if (quiet_done) begin
                    state_d = ST_GRANT;
                end
            end
            ST_BACKOFF: begin
                if (!tx_pending) begin
                    state_d = ST_IDLE;
                end else if (wait_cnt == '0) begin
                    state_d = ST_LISTEN;
                end
            end
            ST_GRANT: begin
                state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!tx_pending) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Wait counter (fixed slot delay and random back-off share it)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (state_q == ST_IDLE && state_d == ST_SLOT) begin
            wait_cnt <= slot_delay;
        end else if (state_q == ST_LISTEN && state_d == ST_BACKOFF) begin
            wait_cnt <= backoff_load;
        end else if ((state_q == ST_SLOT || state_q == ST_BACKOFF) && tick && wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    // Quiet-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (state_q != ST_LISTEN || chan_busy) begin
            quiet_cnt <= '0;
        end else if (tick && !quiet_done) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        rx_enable = 1'b0;
        tx_grant  = 1'b0;
        unique case (state_q)
            ST_LISTEN: rx_enable = 1'b1;
            ST_GRANT:  tx_grant  = 1'b1;
            default: begin
                rx_enable = 1'b0;
                tx_grant  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lbt_sched_chk.sv
module lbt_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_pending,
    input logic chan_busy,
    input logic rx_enable,
    input logic tx_grant
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!tx_grant && !rx_enable));

    // R10
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |=> !tx_grant);

    // R9
    abort_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_pending |=> !tx_grant);

    // R9
    abort_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_pending |=> !rx_enable);

    // R6
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && chan_busy) |=> !tx_grant);

    // R11
    grant_rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_enable && tx_grant));

    // R11
    grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_grant) |-> $past(tx_pending));
endmodule

bind lbt_sched lbt_sched_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_pending (tx_pending),
    .chan_busy  (chan_busy),
    .rx_enable  (rx_enable),
    .tx_grant   (tx_grant)
);

// File: tb/lbt_sched_test.sv
module lbt_sched_test;
    localparam int C   = 2;
    localparam int UPM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_listen = 1'b0;
    logic       cfg_delay = 1'b0;
    logic       tx_pending = 1'b0;
    logic       chan_busy = 1'b0;
    logic [2:0] backoff_exp = 3'd0;
    logic [7:0] slot_num = 8'd0;
    logic [7:0] pre_cycles = 8'd1;
    logic [7:0] turn_units = 8'd1;
    logic [5:0] pkt_bytes = 6'd1;
    logic       rx_enable;
    logic       tx_grant;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    bit rx_seen;

    always #5 clk = ~clk;

    lbt_sched #(.CLKS_PER_UNIT(C), .UNITS_PER_MS(UPM)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_listen  (cfg_listen),
        .cfg_delay   (cfg_delay),
        .tx_pending  (tx_pending),
        .chan_busy   (chan_busy),
        .backoff_exp (backoff_exp),
        .slot_num    (slot_num),
        .pre_cycles  (pre_cycles),
        .turn_units  (turn_units),
        .pkt_bytes   (pkt_bytes),
        .rx_enable   (rx_enable),
        .tx_grant    (tx_grant)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Count edges from the request until the grant is seen (0 if none by limit)
    task automatic wait_grant(output int cnt, input int limit);
        cnt = 0;
        rx_seen = 1'b0;
        forever begin
            @(posedge clk);
            @(negedge clk);
            cnt++;
            if (rx_enable) rx_seen = 1'b1;
            if (tx_grant) break;
            if (cnt >= limit) begin
                cnt = 0;
                break;
            end
        end
    endtask

    task automatic release_req();
        @(negedge clk);
        tx_pending = 1'b0;
        chan_busy  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mode(input bit l, input bit d);
        cfg_listen = l;
        cfg_delay  = d;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int cnt;
        int exp;
        int units;
        int bad;
        int grants;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(!rx_enable && !tx_grant, "R1 outputs during reset", {rx_enable, tx_grant}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rx_enable && !tx_grant, "R1 outputs after reset", {rx_enable, tx_grant}, 0);

        // R2 immediate grant
        set_mode(0, 0);
        chan_busy = 1'b1;
        @(negedge clk);
        tx_pending = 1'b1;
        wait_grant(cnt, 100);
        check(cnt == 1, "R2 immediate grant edge", cnt, 1);
        check(!rx_seen, "R2 receiver stays off", rx_seen, 0);
        // R10 single pulse and no second grant while held
        grants = 0;
        repeat (30) begin
            @(negedge clk);
            if (tx_grant) grants++;
        end
        check(grants == 0, "R10 one grant per held request", grants, 0);
        release_req();

        // R3 R4 fixed slot delay sweep
        set_mode(0, 1);
        bad = 0;
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 2; p++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int t = 0; t < 2; t++) begin
                        slot_num   = 8'(s);
                        pre_cycles = (p == 0) ? 8'd1 : 8'd5;
                        pkt_bytes  = (b == 0) ? 6'd1 : 6'd60;
                        turn_units = (t == 0) ? 8'd1 : 8'd3;
                        chan_busy  = (t == 1);
                        units = int'(pre_cycles) + (int'(pkt_bytes) + 2) * 6
                              + 3 * int'(turn_units) + 40;
                        exp = s * units * C + 2;
                        @(negedge clk);
                        tx_pending = 1'b1;
                        wait_grant(cnt, exp + 50);
                        check(cnt == exp, "R3 R4 slot delay", cnt, exp);
                        if (rx_seen) bad++;
                        release_req();
                    end
                end
            end
        end
        check(bad == 0, "R4 receiver off during slot wait", bad, 0);

        // R5 quiet window sweep, channel clear
        set_mode(1, 0);
        for (int t = 1; t <= 6; t++) begin
            turn_units = 8'(t);
            @(negedge clk);
            tx_pending = 1'b1;
            wait_grant(cnt, 200);
            check(cnt == t * C + 2, "R5 quiet window grant", cnt, t * C + 2);
            check(rx_seen, "R5 receiver enabled while listening", rx_seen, 1);
            release_req();
        end

        // R6 busy holds listening; R5 grant timed from busy drop
        turn_units = 8'd4;
        chan_busy  = 1'b1;
        @(negedge clk);
        tx_pending = 1'b1;
        @(negedge clk);
        bad = 0;
        repeat (50) begin
            @(negedge clk);
            if (!rx_enable || tx_grant) bad++;
        end
        check(bad == 0, "R6 busy keeps listening without grant", bad, 0);
        chan_busy = 1'b0;
        wait_grant(cnt, 200);
        check(cnt == 4 * C + 1, "R5 grant after busy drop", cnt, 4 * C + 1);
        release_req();

        // R9 abort during listen
        chan_busy = 1'b1;
        @(negedge clk);
        tx_pending = 1'b1;
        repeat (10) @(negedge clk);
        tx_pending = 1'b0;
        @(negedge clk);
        check(!rx_enable, "R9 receiver drops on abort", rx_enable, 0);
        chan_busy = 1'b0;
        repeat (3) @(negedge clk);

        // R9 abort during slot wait
        set_mode(0, 1);
        slot_num = 8'd3; pre_cycles = 8'd5; pkt_bytes = 6'd60; turn_units = 8'd3;
        @(negedge clk);
        tx_pending = 1'b1;
        repeat (20) @(negedge clk);
        tx_pending = 1'b0;
        bad = 0;
        repeat (3000) begin
            @(negedge clk);
            if (tx_grant || rx_enable) bad++;
        end
        check(bad == 0, "R9 no grant after slot abort", bad, 0);

        // R7 R8 random back-off
        set_mode(1, 1);
        turn_units = 8'd2;
        for (int n = 0; n < 4; n++) begin
            int first;
            bit differ;
            int maxgap;
            backoff_exp = 3'(n);
            maxgap = ((1 << n) - 1) * UPM * C + 1;
            chan_busy = 1'b1;
            @(negedge clk);
            tx_pending = 1'b1;
            bad = 0;
            first = -1;
            differ = 1'b0;
            for (int k = 0; k < 16; k++) begin
                int gap;
                while (!rx_enable) @(negedge clk);
                while (rx_enable) @(negedge clk);
                gap = 0;
                while (!rx_enable) begin
                    gap++;
                    if (tx_grant) bad++;
                    @(negedge clk);
                end
                if (gap < 1 || gap > maxgap) bad++;
                if (n == 0 && gap != 1) bad++;
                if (first < 0) first = gap;
                else if (gap != first) differ = 1'b1;
            end
            check(bad == 0, "R7 back-off gap within bound", bad, 0);
            if (n >= 2) check(differ, "R8 back-off lengths vary", differ, 1);
            chan_busy = 1'b0;
            wait_grant(cnt, 1000);
            check(cnt != 0, "R7 grant once channel clears", cnt, 1);
            release_req();
        end

        // R9 abort during back-off
        backoff_exp = 3'd3;
        chan_busy = 1'b1;
        @(negedge clk);
        tx_pending = 1'b1;
        while (!rx_enable) @(negedge clk);
        while (rx_enable) @(negedge clk);
        tx_pending = 1'b0;
        bad = 0;
        repeat (500) begin
            @(negedge clk);
            if (tx_grant || rx_enable) bad++;
        end
        check(bad == 0, "R9 no activity after back-off abort", bad, 0);
        chan_busy = 1'b0;

        // R10 R11 grant width and exclusivity in listen mode
        set_mode(1, 0);
        turn_units = 8'd1;
        @(negedge clk);
        tx_pending = 1'b1;
        wait_grant(cnt, 100);
        check(!rx_enable, "R11 receiver off with grant", rx_enable, 0);
        @(negedge clk);
        check(!tx_grant, "R10 grant is one cycle", tx_grant, 0);
        release_req();

        finish_run();
    end
endmodule